// File: doc/BRIEF.md
# Chip-Select Matcher with Spare Redirect

This block takes an already normalized memory input address and decides which chip-select (rank) responds to it. A bank of N entries is presented on its inputs. Each entry has a base, a mask, an enable bit and a 4-bit entry number. An entry responds when every address bit that its mask leaves clear agrees with its base. Entries that are not enabled never respond. Among the entries that respond, the one at the lowest position wins.

After the winner is found, online-spare substitution is applied. A pair of 4-bit numbers names a bad rank and the spare that replaces it. When the winner's entry number equals the bad number, the result becomes the spare number. This happens only if the bad and spare numbers are not both the invalid code 4'hF. The spare's own base, mask and enable take no part in this step. Its entry only has to exist.

The scan happens combinationally in one cycle, and the outcome is registered. A small state register holds the kind of the last response: ST_IDLE when no request came, ST_HIT for a plain match, ST_REMAP for a redirected match, ST_MISS when nothing matched, and ST_NOSPARE when a redirect was due but no entry carries the spare number. Every state can move to every other state on each clock. With no request the next state is ST_IDLE. With a request the next state is ST_MISS, ST_REMAP, ST_NOSPARE or ST_HIT, chosen in that order of precedence.

Top module: `csm_top`

## Requirements
- R1: An enabled entry matches when (req_addr AND NOT mask) equals (base AND NOT mask); bits set in the mask are ignored.
- R2: An entry whose enable bit is 0 never matches, whatever its base and mask.
- R3: When several entries match, the entry at the lowest position (entry 0 is position 0) is selected, and rsp_cs carries its entry number.
- R4: When no entry matches, rsp_noaddr is 1, and rsp_hit, rsp_redir and rsp_nospare are 0, with rsp_cs = 0. While rsp_valid is 1, exactly one of rsp_hit, rsp_noaddr and rsp_nospare is 1.
- R5: When the selected entry's number equals bad_num, the bad and spare numbers are not both 4'hF, and some entry carries spare_num, the response has rsp_hit = 1, rsp_redir = 1 and rsp_cs = spare_num.
- R6: The redirect succeeds even when the spare entry is disabled or its base and mask would not match the address.
- R7: When a redirect is due but no entry number equals spare_num (a spare_num of 4'hF never counts as carried), the response has rsp_nospare = 1, rsp_hit = 0, rsp_redir = 0 and rsp_cs = 0.
- R8: A request with req_valid = 1 at a rising edge is answered on the outputs after that edge with rsp_valid = 1. After a rising edge with req_valid = 0, or during reset (active-low rst_n), every output is 0.
- R9: When bad_num and spare_num are both 4'hF, no redirect occurs, even if the selected entry's number is 4'hF. When only bad_num is 4'hF, an entry numbered 4'hF is still redirected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A lookup is requested this cycle |
| req_addr | input | AW | Normalized input address |
| cs_base | input | N*AW | Entry bases, entry i at bits [i*AW +: AW] |
| cs_mask | input | N*AW | Entry masks, a set bit is ignored in the compare |
| cs_en | input | N | Entry enable bits |
| cs_num | input | N*NW | Entry numbers, entry i at bits [i*NW +: NW] |
| bad_num | input | NW | Number of the rank nominated as bad, 4'hF invalid |
| spare_num | input | NW | Number of the spare rank, 4'hF invalid |
| rsp_valid | output | 1 | A response is present |
| rsp_hit | output | 1 | A chip-select was found |
| rsp_cs | output | NW | Final chip-select number, 0 when rsp_hit is 0 |
| rsp_redir | output | 1 | The result was redirected to the spare |
| rsp_noaddr | output | 1 | No entry matched |
| rsp_nospare | output | 1 | A redirect was due but the spare number is not present |

## Verification
Within a single cycle, the priority pick and the spare substitution act on the same request. So does the check that the spare exists. The bench therefore includes cases where the lowest matching entry is the bad one while a higher entry also matches. It also includes a case where the spare entry is disabled, and one where the spare number belongs to no entry. It applies random configurations, where numbers collide often, to mix all three outcomes. A behavioural model in the bench computes the expected response for each request, and every output is compared with that model on every clock.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int unsigned CSM_NUM_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_REMAP,
        ST_MISS,
        ST_NOSPARE
    } csm_state_t;
endpackage

// File: rtl/csm_match.sv
module csm_match #(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0]   addr,
    input  logic [N*AW-1:0] base,
    input  logic [N*AW-1:0] mask,
    input  logic [N-1:0]    en,
    output logic [N-1:0]    hit
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [AW-1:0] diff;
        assign diff   = (addr ^ base[g*AW +: AW]) & ~mask[g*AW +: AW];
        assign hit[g] = en[g] && (diff == '0);
    end
endmodule

// File: rtl/csm_prio.sv
module csm_prio #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
    assign found = |req;
endmodule

// File: rtl/csm_spare.sv
module csm_spare #(
    parameter int unsigned N  = 8,
    parameter int unsigned NW = 4
) (
    input  logic [N*NW-1:0] nums,
    input  logic [NW-1:0]   spare,
    output logic            present
);
    logic [N-1:0] eq;
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = (nums[g*NW +: NW] == spare);
    end
    assign present = (spare != {NW{1'b1}}) && (|eq);
endmodule

// File: rtl/csm_top.sv
module csm_top
    import csm_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned AW = 32,
    parameter int unsigned NW = CSM_NUM_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [N*AW-1:0] cs_base,
    input  logic [N*AW-1:0] cs_mask,
    input  logic [N-1:0]    cs_en,
    input  logic [N*NW-1:0] cs_num,
    input  logic [NW-1:0]   bad_num,
    input  logic [NW-1:0]   spare_num,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [NW-1:0]   rsp_cs,
    output logic            rsp_redir,
    output logic            rsp_noaddr,
    output logic            rsp_nospare
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [NW-1:0] INVAL = {NW{1'b1}};

    logic [N-1:0]  hit_vec;
    logic          any_hit;
    logic [IW-1:0] sel_idx;
    logic [NW-1:0] sel_num;
    logic          spare_ok;
    logic          need_redir;

    csm_state_t    state_q, state_d;
    logic [NW-1:0] cs_q, cs_d;

    csm_match #(.N(N), .AW(AW)) u_match (
        .addr (req_addr),
        .base (cs_base),
        .mask (cs_mask),
        .en   (cs_en),
        .hit  (hit_vec)
    );

    csm_prio #(.N(N)) u_prio (
        .req   (hit_vec),
        .found (any_hit),
        .idx   (sel_idx)
    );

    csm_spare #(.N(N), .NW(NW)) u_spare (
        .nums    (cs_num),
        .spare   (spare_num),
        .present (spare_ok)
    );

    assign sel_num    = cs_num[sel_idx*NW +: NW];
    assign need_redir = (sel_num == bad_num) &&
                        !((bad_num == INVAL) && (spare_num == INVAL));

    always_comb begin
        state_d = ST_IDLE;
        cs_d    = '0;
        if (req_valid) begin
            if (!any_hit) begin
                state_d = ST_MISS;
            end else if (need_redir) begin
                if (spare_ok) begin
                    state_d = ST_REMAP;
                    cs_d    = spare_num;
                end else begin
                    state_d = ST_NOSPARE;
                end
            end else begin
                state_d = ST_HIT;
                cs_d    = sel_num;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= '0;
        end else begin
            state_q <= state_d;
            cs_q    <= cs_d;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_hit     = 1'b0;
        rsp_redir   = 1'b0;
        rsp_noaddr  = 1'b0;
        rsp_nospare = 1'b0;
        rsp_cs      = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_cs    = cs_q;
            end
            ST_REMAP: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_redir = 1'b1;
                rsp_cs    = cs_q;
            end
            ST_MISS: begin
                rsp_valid  = 1'b1;
                rsp_noaddr = 1'b1;
            end
            ST_NOSPARE: begin
                rsp_valid   = 1'b1;
                rsp_nospare = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/csm_chk.sv
module csm_chk #(
    parameter int unsigned NW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [NW-1:0] spare_num,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic [NW-1:0] rsp_cs,
    input logic          rsp_redir,
    input logic          rsp_noaddr,
    input logic          rsp_nospare
);
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8
    AST_IDLE_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_redir || rsp_noaddr || rsp_nospare)); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_noaddr, rsp_nospare}) == 1)); // R4
    AST_REDIR_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redir |-> rsp_hit); // R5
    AST_REDIR_TO_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redir |-> (rsp_cs == $past(spare_num))); // R5
    AST_NOHIT_CS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_cs == '0)); // R7
endmodule

bind csm_top csm_chk #(.NW(NW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .spare_num   (spare_num),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_cs      (rsp_cs),
    .rsp_redir   (rsp_redir),
    .rsp_noaddr  (rsp_noaddr),
    .rsp_nospare (rsp_nospare)
);

// File: tb/csm_top_test.sv
`timescale 1ns/1ps
module csm_top_test;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] base_a [N];
    logic [AW-1:0] mask_a [N];
    logic [NW-1:0] num_a  [N];
    logic [N-1:0]  cs_en;
    logic [NW-1:0] bad_num, spare_num;
    logic [N*AW-1:0] cs_base, cs_mask;
    logic [N*NW-1:0] cs_num;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cs_base[i*AW +: AW] = base_a[i];
            cs_mask[i*AW +: AW] = mask_a[i];
            cs_num[i*NW +: NW]  = num_a[i];
        end
    end

    logic          rsp_valid, rsp_hit, rsp_redir, rsp_noaddr, rsp_nospare;
    logic [NW-1:0] rsp_cs;

    csm_top #(.N(N), .AW(AW), .NW(NW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cs_base(cs_base), .cs_mask(cs_mask), .cs_en(cs_en), .cs_num(cs_num),
        .bad_num(bad_num), .spare_num(spare_num),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cs(rsp_cs),
        .rsp_redir(rsp_redir), .rsp_noaddr(rsp_noaddr), .rsp_nospare(rsp_nospare)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R8 reset";
    string exp_tag = "R8 reset";
    logic [8:0] exp_vec = '0;

    // packed as {valid, hit, redir, noaddr, nospare, cs[3:0]}
    function automatic logic [8:0] model();
        int sel = -1;
        bit found_spare = 0;
        if (!req_valid) return '0;
        for (int i = 0; i < N; i++) begin
            if (sel < 0 && cs_en[i] && (((req_addr ^ base_a[i]) & ~mask_a[i]) == 0)) sel = i;
        end
        if (sel < 0) return 9'b1_0010_0000;
        if (num_a[sel] == bad_num && !(bad_num == 15 && spare_num == 15)) begin
            for (int j = 0; j < N; j++) if (num_a[j] == spare_num && spare_num != 15) found_spare = 1;
            if (found_spare) return {5'b11100, spare_num};
            return 9'b1_0001_0000;
        end
        return {5'b11000, num_a[sel]};
    endfunction

    always @(posedge clk) begin
        exp_tag <= cur_tag;
        if (!rst_n) exp_vec <= '0;
        else        exp_vec <= model();
    end

    always @(negedge clk) begin
        logic [8:0] act;
        if (!done) begin
            act = {rsp_valid, rsp_hit, rsp_redir, rsp_noaddr, rsp_nospare, rsp_cs};
            n_cmp++;
            if (act !== exp_vec) begin
                n_bad++;
                $display("FAIL %s: got v/h/r/na/ns/cs=%b cs=%0h expected %b cs=%0h",
                         exp_tag, act[8:4], act[3:0], exp_vec[8:4], exp_vec[3:0]);
            end
        end
    end

    task automatic default_cfg();
        for (int i = 0; i < N; i++) begin
            base_a[i] = AW'(i) << 24;
            mask_a[i] = 32'h00FF_FFFF;
            num_a[i]  = NW'(i);
        end
        cs_en = '1;
        bad_num = 4'hF;
        spare_num = 4'hF;
    endtask

    task automatic req(input string tag, input logic [AW-1:0] a);
        @(negedge clk); #0.5;
        cur_tag = tag;
        req_valid = 1'b1;
        req_addr = a;
    endtask

    task automatic idle(input string tag);
        @(negedge clk); #0.5;
        cur_tag = tag;
        req_valid = 1'b0;
    endtask

    initial begin
        default_cfg();
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1'b1;
        idle("R8 idle after reset");
        // R1 masked compare
        req("R1 masked match entry 3", 32'h0312_3456);
        mask_a[1] = 32'h0FFF_FFFF;
        req("R1 wide mask entry 1 preferred over 6", 32'h0600_0001);
        default_cfg();
        base_a[2] = 32'h0200_0010; mask_a[2] = 32'h00FF_FF0F;
        req("R1 base bit in unmasked nibble differs", 32'h0200_0020);
        req("R1 base bit in unmasked nibble equal", 32'h0200_0015);
        default_cfg();
        // R2 disabled
        cs_en[3] = 1'b0;
        req("R2 disabled entry gives no address R4", 32'h0300_0000);
        cs_en = '1;
        // R3 priority
        mask_a[5] = '1;
        req("R3 lowest of entries 5 and 7", 32'h0700_0000);
        req("R3 lower entry 2 beats 5", 32'h0200_0000);
        default_cfg();
        req("R4 address beyond all entries", 32'h0900_0000);
        idle("R8 no request");
        // R5 redirect
        bad_num = 4'd2; spare_num = 4'd6;
        req("R5 bad rank 2 to spare 6", 32'h0211_0000);
        req("R5 non-bad entry untouched", 32'h0411_0000);
        mask_a[1] = 32'h0FFF_FFFF;
        req("R5 R3 lower entry 1 wins, no redirect", 32'h0200_0000);
        mask_a[1] = 32'h00FF_FFFF;
        // R6 spare entry disabled and mismatched
        cs_en[6] = 1'b0; base_a[6] = 32'hDEAD_0000; mask_a[6] = '0;
        req("R6 disabled spare still used", 32'h0200_0000);
        default_cfg();
        // R7 missing spare
        bad_num = 4'd2; spare_num = 4'd9;
        req("R7 spare number absent", 32'h0200_0000);
        spare_num = 4'hF;
        req("R7 spare invalid with bad valid", 32'h0200_0000);
        default_cfg();
        // R9 invalid codes
        num_a[4] = 4'hF;
        req("R9 both invalid no redirect", 32'h0400_0000);
        spare_num = 4'd5;
        req("R9 bad invalid spare valid redirects", 32'h0400_0000);
        default_cfg();
        // back-to-back and random mixes
        for (int k = 0; k < 300; k++) begin
            for (int i = 0; i < N; i++) begin
                base_a[i] = {4'($urandom_range(0, 3)), 28'($urandom)};
                mask_a[i] = {4'($urandom_range(0, 1) ? 4'h0 : 4'hF), 28'h0FFF_FFF};
                num_a[i]  = NW'($urandom_range(0, 15));
            end
            cs_en     = N'($urandom);
            bad_num   = NW'($urandom_range(0, 15));
            spare_num = NW'($urandom_range(0, 15));
            if ($urandom_range(0, 4) == 0) idle("R8 random idle");
            else req("R3 R5 R7 random mix", {4'($urandom_range(0, 3)), 28'($urandom)});
        end
        idle("R8 final idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule